// File: doc/BRIEF.md
# Toggle-Only Word Write Sequencer

This block performs word writes into a storage array whose cells cannot be driven to a chosen value; a cell can only be inverted. A write request carries a target address, a 16-bit data word and the 5 check bits that belong to it. The sequencer reads the word currently held at that address, works out which of the 21 codeword bits differ from the requested codeword, and then issues a single toggle strobe whose mask inverts exactly those bits. When the stored codeword already equals the requested one, no toggle strobe is issued at all.

Requests enter through a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. While the sequencer is busy, `req_ready` is low, so any `req_valid` pulse in that window is not taken and leaves no trace. A requester that must not lose a write keeps `req_valid` and its payload steady until it sees `req_ready`. Completion is reported by a one-cycle `done` strobe. The `toggled` output tells whether that write actually inverted any cells, and it holds its value until the next completion.

The array side has a read port and a toggle port. The read data is expected combinationally from `arr_addr` while `arr_rd_en` is high. On every clock edge where `arr_tgl_en` is high, the array replaces the addressed word with that word XOR `arr_tgl_mask`. The read phase and the toggle phase each last a parameterised number of cycles (`RD_CYC`, `TGL_CYC`). The toggle strobe itself lasts one cycle, and the mask stays steady for the rest of the toggle phase.

Top module: `tws_write_seq`

## Requirements
- R1: While reset is active and right after it ends, `req_ready` is 1 and `arr_rd_en`, `arr_tgl_en` and `done` are 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance up to and including the `done` cycle. A `req_valid` pulse in that window changes no array word and starts no extra operation.
- R3: After acceptance, `arr_rd_en` is 1 for exactly `RD_CYC` cycles, with `arr_addr` equal to the accepted address. This read happens before any toggle strobe.
- R4: The codeword is `{chk[4:0], data[15:0]}`, with data in bits 15:0 and check bits in bits 20:16. The toggle mask equals the stored codeword XOR the requested codeword over all 21 bits.
- R5: If the stored and requested codewords are equal, no toggle strobe is issued and `toggled` is 0 at `done`.
- R6: If they differ, exactly one one-cycle `arr_tgl_en` strobe is issued, the mask is held for the `TGL_CYC` cycles of the toggle phase, and `toggled` is 1 at `done`.
- R7: `done` is a one-cycle strobe. Counting the acceptance edge as edge 0, `done` goes high after edge `RD_CYC+1` when no toggle is needed and after edge `RD_CYC+1+TGL_CYC` otherwise. `req_ready` returns to 1 one cycle later.
- R8: After `done`, the addressed array word equals the requested codeword.
- R9: The toggle strobe occurs no more than `BUDGET_CYC` cycles after acceptance. The default is 25 cycles, which is 100 ns at 4 ns per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | New data word |
| req_chk | input | CHK_W | Check bits of the new word |
| arr_rd_en | output | 1 | Array read enable |
| arr_addr | output | ADDR_W | Array address for both read and toggle |
| arr_rd_data | input | DATA_W+CHK_W | Stored codeword at `arr_addr` |
| arr_tgl_en | output | 1 | One-cycle toggle strobe |
| arr_tgl_mask | output | DATA_W+CHK_W | Bits to invert |
| done | output | 1 | One-cycle completion strobe |
| toggled | output | 1 | The last write inverted at least one bit |

## Verification
The hardest situations to reach from the ports are a write that leaves the stored codeword unchanged, and a write whose only differences are in the check bits. Random payloads almost never produce either one. The stimulus therefore reuses the codeword the bench knows is stored for a quarter of the random writes, and it adds directed writes that change only the check field. A further hard case is a request that appears while the sequencer is busy. Directed writes raise `req_valid` for one cycle, with a payload aimed at a different address, during the read phase. The bench then confirms that this other word is untouched and that no second read starts after `done`.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_CMP  = 3'd2,
    ST_TGL  = 3'd3,
    ST_DONE = 3'd4
  } tws_state_e;
endpackage

// File: rtl/tws_diff.sv
module tws_diff #(
  parameter int CW = 21
) (
  input  logic [CW-1:0] stored,
  input  logic [CW-1:0] wanted,
  output logic [CW-1:0] mask,
  output logic          any
);
  always_comb begin
    mask = stored ^ wanted;
    any  = |mask;
  end
endmodule

// File: rtl/tws_timer.sv
module tws_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

  // R7
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !last) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tws_write_seq.sv
module tws_write_seq
  import tws_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CHK_W      = 5,
  parameter int RD_CYC     = 2,
  parameter int TGL_CYC    = 3,
  parameter int BUDGET_CYC = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_data,
  input  logic [CHK_W-1:0]        req_chk,
  output logic                    arr_rd_en,
  output logic [ADDR_W-1:0]       arr_addr,
  input  logic [DATA_W+CHK_W-1:0] arr_rd_data,
  output logic                    arr_tgl_en,
  output logic [DATA_W+CHK_W-1:0] arr_tgl_mask,
  output logic                    done,
  output logic                    toggled
);
  localparam int CW     = DATA_W + CHK_W;
  localparam int PH_MAX = (RD_CYC > TGL_CYC) ? RD_CYC : TGL_CYC;
  localparam int TMR_W  = $clog2(PH_MAX + 1);
  localparam int SPAN   = BUDGET_CYC + RD_CYC + TGL_CYC + 4;
  localparam int BUD_W  = $clog2(SPAN + 1);

  tws_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     new_q, stored_q, mask_q, diff_mask;
  logic              diff_any, toggled_q, tgl_pulse_q;
  logic              tmr_load, tmr_last;
  logic [TMR_W-1:0]  tmr_val;
  logic [BUD_W-1:0]  since_acc_q;
  logic              accept;

  assign accept = req_valid && (state_q == ST_IDLE);

  tws_diff #(.CW(CW)) u_diff (
    .stored (stored_q),
    .wanted (new_q),
    .mask   (diff_mask),
    .any    (diff_any)
  );

  tws_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(RD_CYC - 1);
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_READ;
        tmr_load = 1'b1;
      end
      ST_READ: if (tmr_last) state_d = ST_CMP;
      ST_CMP: begin
        if (diff_any) begin
          state_d  = ST_TGL;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(TGL_CYC - 1);
        end else begin
          state_d  = ST_DONE;
        end
      end
      ST_TGL:  if (tmr_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      new_q       <= '0;
      stored_q    <= '0;
      mask_q      <= '0;
      toggled_q   <= 1'b0;
      tgl_pulse_q <= 1'b0;
      since_acc_q <= '0;
    end else begin
      state_q     <= state_d;
      tgl_pulse_q <= (state_q == ST_CMP) && diff_any;
      if (accept) begin
        addr_q      <= req_addr;
        new_q       <= {req_chk, req_data};
        since_acc_q <= '0;
      end else if (since_acc_q != BUD_W'(SPAN)) begin
        since_acc_q <= since_acc_q + 1'b1;
      end
      if (state_q == ST_READ && tmr_last) stored_q <= arr_rd_data;
      if (state_q == ST_CMP) begin
        mask_q    <= diff_mask;
        toggled_q <= diff_any;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign arr_rd_en    = (state_q == ST_READ);
  assign arr_addr     = addr_q;
  assign arr_tgl_en   = tgl_pulse_q;
  assign arr_tgl_mask = mask_q;
  assign done         = (state_q == ST_DONE);
  assign toggled      = toggled_q;

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && arr_rd_en));
  // R3
  tgl_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_tgl_en |-> (!arr_rd_en && !req_ready && !done));
  // R6
  single_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_tgl_en |=> !arr_tgl_en);
  // R6
  tgl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_tgl_en |-> (arr_tgl_mask != '0));
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TGL && $past(state_q) == ST_TGL) |-> $stable(arr_tgl_mask));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R9
  tgl_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_tgl_en |-> (since_acc_q <= BUD_W'(BUDGET_CYC)));
endmodule

// File: tb/tws_write_seq_tb.sv
module tws_write_seq_tb;
  localparam int ADDR_W = 16, DATA_W = 16, CHK_W = 5;
  localparam int RD = 2, TG = 3, CW = DATA_W + CHK_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [CHK_W-1:0]  req_chk = '0;
  logic arr_rd_en, arr_tgl_en, done, toggled;
  logic [ADDR_W-1:0] arr_addr;
  logic [CW-1:0] arr_rd_data, arr_tgl_mask;

  logic [CW-1:0] mem [16];
  logic [CW-1:0] shadow [16];
  logic [CW-1:0] last_mask;
  int strobes = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tws_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W),
                  .RD_CYC(RD), .TGL_CYC(TG), .BUDGET_CYC(25)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_chk(req_chk),
    .arr_rd_en(arr_rd_en), .arr_addr(arr_addr), .arr_rd_data(arr_rd_data),
    .arr_tgl_en(arr_tgl_en), .arr_tgl_mask(arr_tgl_mask),
    .done(done), .toggled(toggled));

  assign arr_rd_data = mem[arr_addr[3:0]];

  always @(posedge clk) begin
    if (arr_tgl_en) begin
      mem[arr_addr[3:0]] <= mem[arr_addr[3:0]] ^ arr_tgl_mask;
      last_mask <= arr_tgl_mask;
      strobes <= strobes + 1;
    end
  end

  function automatic int exp_latency(logic [CW-1:0] oldw, logic [CW-1:0] neww);
    return RD + 1 + ((oldw != neww) ? TG : 0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [15:0] d, logic [4:0] c, bit inject);
    logic [CW-1:0] oldw = shadow[a[3:0]];
    logic [CW-1:0] neww = {c, d};
    logic [3:0] other = a[3:0] + 4'd1;
    int s0 = strobes, lat = -1, rd_cnt = 0;
    bit bad_addr = 0, ready_busy = 0, tgl_before_rd = 0;
    logic tg = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_chk = c;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (arr_rd_en) begin rd_cnt++; if (arr_addr !== a) bad_addr = 1; end
    for (int k = 1; k <= 100; k++) begin
      if (inject && k == 1) begin
        req_valid = 1'b1; req_addr = {12'h0, other}; req_data = ~d; req_chk = ~c;
      end
      if (inject && k == 2) req_valid = 1'b0;
      @(negedge clk);
      if (strobes != s0 && rd_cnt == 0) tgl_before_rd = 1;
      if (arr_rd_en) begin rd_cnt++; if (arr_addr !== a) bad_addr = 1; end
      if (done) begin lat = k; tg = toggled; break; end
      if (req_ready) ready_busy = 1;
    end
    req_valid = 1'b0;
    check("R7 latency", lat, exp_latency(oldw, neww));
    check("R2 ready low while busy", {31'd0, ready_busy}, 0);
    check("R3 read cycles", rd_cnt, RD);
    check("R3 read address", {31'd0, bad_addr}, 0);
    check("R3 read before toggle", {31'd0, tgl_before_rd}, 0);
    if (oldw == neww) begin
      check("R5 no strobe", strobes - s0, 0);
      check("R5 toggled flag", {31'd0, tg}, 0);
    end else begin
      check("R6 one strobe", strobes - s0, 1);
      check("R6 toggled flag", {31'd0, tg}, 1);
      check("R4 mask", {11'd0, last_mask}, {11'd0, oldw ^ neww});
    end
    check("R8 stored word", {11'd0, mem[a[3:0]]}, {11'd0, neww});
    @(negedge clk);
    check("R7 ready after done", {31'd0, req_ready}, 1);
    check("R7 done one cycle", {31'd0, done}, 0);
    if (inject) begin
      check("R2 ignored no restart", {31'd0, arr_rd_en}, 0);
      check("R2 ignored word intact", {11'd0, mem[other]}, {11'd0, shadow[other]});
    end
    shadow[a[3:0]] = neww;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin
      mem[i] = CW'($urandom);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'd0, req_ready}, 1);
    check("R1 quiet in reset", {29'd0, arr_rd_en, arr_tgl_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, req_ready}, 1);
    check("R1 quiet after reset", {29'd0, arr_rd_en, arr_tgl_en, done}, 0);

    // directed corner cases
    do_write(16'h0003, shadow[3][15:0], shadow[3][20:16], 0);   // R5 unchanged
    do_write(16'h0004, ~shadow[4][15:0], ~shadow[4][20:16], 0); // R4 all bits
    do_write(16'h0005, shadow[5][15:0], ~shadow[5][20:16], 0);  // R4 check bits only
    do_write(16'hFFF6, shadow[6][15:0] ^ 16'h8000, shadow[6][20:16], 0);
    do_write(16'h0007, 16'h1234, 5'h11, 1);                     // R2 busy pulse
    do_write(16'h0008, shadow[8][15:0], shadow[8][20:16], 1);   // R2 busy, no change
    do_write(16'h0007, 16'h1234, 5'h11, 0);                     // R5 repeat

    for (int n = 0; n < 60; n++) begin
      logic [15:0] a = {12'h0, 4'($urandom)};
      if (($urandom % 4) == 0)
        do_write(a, shadow[a[3:0]][15:0], shadow[a[3:0]][20:16], n % 5 == 0);
      else
        do_write(a, 16'($urandom), 5'($urandom), n % 5 == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule